// File: doc/BRIEF.md
# Display Clock Synthesizer Control Front End

This block sits between a host register bus and a display clock synthesizer. The host writes the feedback and reference divisor values, a post-divider value and a DAC multiplier in one settings word. The divisor word is packed at once and goes to two identical divisor slots. The post-divider and the multiplier are only staged in shadow storage. They reach the control and multiplier words when the host issues an enable command.

After an enable, a settle timer counts microsecond ticks before the oscillator's run indication is looked at. The controller then samples an oscillator acknowledge on a bounded number of ticks. If the acknowledge is seen, the block reports lock. If it is not seen, the block raises a busy error. A disable command clears the control word and the lock and error state. Every value the block holds can be read back over the host port. The run bit of the control readback stays hidden until lock.

Top module: `dclk_synth_ctl`

## Requirements
- R1: A write to address 0 packs the divisor word as (field[7:0]−2) in bits 7:0, (field[15:8]−2) in bits 15:8 and (field[23:16]−2) in bits 23:16, with bits 31:24 zero. The word is visible on `div_word` one clock later.
- R2: Reads of address 0 and address 1 both return the same packed divisor word.
- R3: A settings write only stages the post-divider (wdata[27:24]) and the multiplier (wdata[31:28]). `ctrl_word` and `mult_word` do not change. Address 4 reads back the staged pair at the same bit positions.
- R4: An accepted enable (a write to address 1 with wdata[0]=1 and wdata[1]=0) loads `ctrl_word` with the following fields: value 6 in bits 12:9, the staged post-divider in bits 19:16, bits 25:24 zero, and bits 26, 28 and 31 set. All other bits are zero.
- R5: An accepted enable loads `mult_word` with (multiplier−1) in bits 7:0 and again in bits 15:8.
- R6: `locked` stays low for the first SETTLE_TICKS ticks after an accepted enable. It rises one clock after the first later tick on which `osc_ack` is high.
- R7: If `osc_ack` is low on POLL_LIMIT consecutive poll ticks, `busy_err` goes high and `locked` stays low. In that state `osc_ack` has no effect.
- R8: A command write with wdata[1]=1 (disable, which wins over enable) clears `ctrl_word`, `locked` and `busy_err` on the next clock.
- R9: Address 2 reads `ctrl_word` with bit 31 forced to zero until `locked` is high. Address 3 reads `mult_word`. Address 5 reads {settling, busy_err, locked} in bits 2:0.
- R10: An enable issued while a settle or poll is in progress is ignored. `ctrl_word` and `mult_word` keep their values, and the lock time is not moved.
- R11: After reset, all outputs and all readbacks are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 3 | Host register address (write and read) |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data for host_addr (combinational) |
| osc_ack | input | 1 | Oscillator run indication |
| div_word | output | 32 | Packed divisor word |
| ctrl_word | output | 32 | Control word to the synthesizer |
| mult_word | output | 32 | DAC multiplier word |
| locked | output | 1 | Synthesizer reported running |
| busy_err | output | 1 | Run indication never seen within the poll window |

## Verification
Two different settings words are used. Each gives a distinct divisor, post-divider and multiplier, so a mis-packed field or a field taken from the wrong write shows up on the outputs. The second settings word and an enable arrive in the middle of a settle. This separates "staged until enable" from "applied at once" and checks that the lock moment is not moved. The settle runs three ways: acknowledge present, acknowledge absent (which must end in the busy error), and sparse ticks. These cases separate counting ticks from counting clocks. A combined enable and disable write checks that disable has priority.

// File: rtl/dclk_pkg.sv
// Shared types, register addresses and word builders for the display
// clock synthesizer control front end. Assumes 8-bit divisor fields and
// 4-bit post-divider and multiplier fields in the settings word.
package dclk_pkg;
    localparam int WORD_W = 32;
    localparam int FLD_W  = 8;
    localparam int P1_W   = 4;
    localparam int MUL_W  = 4;

    // host addresses
    localparam logic [2:0] A_SETTINGS = 3'd0;
    localparam logic [2:0] A_DIV_B    = 3'd1;
    localparam logic [2:0] A_COMMAND  = 3'd1;
    localparam logic [2:0] A_CTRL     = 3'd2;
    localparam logic [2:0] A_MULT     = 3'd3;
    localparam logic [2:0] A_STAGED   = 3'd4;
    localparam logic [2:0] A_STATUS   = 3'd5;

    typedef enum logic [2:0] {
        T_IDLE, T_SETTLE, T_POLL, T_LOCK, T_FAIL
    } tmr_state_t;

    typedef struct packed {
        logic [MUL_W-1:0] mul;
        logic [P1_W-1:0]  p1;
        logic [FLD_W-1:0] n;
        logic [FLD_W-1:0] m1;
        logic [FLD_W-1:0] m2;
    } settings_t;

    function automatic logic [WORD_W-1:0] pack_div(input settings_t s);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[7:0]   = s.m2 - 8'd2;
        w[15:8]  = s.m1 - 8'd2;
        w[23:16] = s.n  - 8'd2;
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] build_ctrl(input logic [P1_W-1:0] p1);
        logic [WORD_W-1:0] w;
        w        = '0;
        w[12:9]  = 4'd6;      // clock phase
        w[19:16] = p1;        // post divider
        w[25:24] = 2'b00;     // divide-by-10 selection
        w[26]    = 1'b1;      // DAC mode
        w[28]    = 1'b1;      // legacy text mode off
        w[31]    = 1'b1;      // oscillator run
        return w;
    endfunction

    function automatic logic [WORD_W-1:0] build_mult(input logic [MUL_W-1:0] m);
        logic [7:0] v;
        v = 8'(m) - 8'd1;
        return {16'd0, v, v};
    endfunction
endpackage

// File: rtl/dclk_shadow_regs.sv
// Holds the divisor slots, the staged post-divider and multiplier, and the
// committed control and multiplier words. Assumes start and stop never
// arrive together (the top gives stop priority).
module dclk_shadow_regs
    import dclk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_wr,
    input  settings_t         set_data,
    input  logic              start,
    input  logic              stop,
    output logic [WORD_W-1:0] div_a,
    output logic [WORD_W-1:0] div_b,
    output logic [P1_W-1:0]   p1_staged,
    output logic [MUL_W-1:0]  mul_staged,
    output logic [WORD_W-1:0] ctrl_q,
    output logic [WORD_W-1:0] mult_q
);
    // divisor slots and staged fields, loaded on a settings write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_a      <= '0;
            div_b      <= '0;
            p1_staged  <= '0;
            mul_staged <= '0;
        end else if (set_wr) begin
            div_a      <= pack_div(set_data);
            div_b      <= pack_div(set_data);
            p1_staged  <= set_data.p1;
            mul_staged <= set_data.mul;
        end
    end

    // committed words: built on start, control cleared on stop
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
            mult_q <= '0;
        end else if (stop) begin
            ctrl_q <= '0;
        end else if (start) begin
            ctrl_q <= build_ctrl(p1_staged);
            mult_q <= build_mult(mul_staged);
        end
    end
endmodule

// File: rtl/dclk_settle_timer.sv
// Counts SETTLE_TICKS microsecond ticks after a start, then samples the
// oscillator acknowledge on up to POLL_LIMIT ticks. Ends in lock or fail.
// Assumes stop has priority over start.
module dclk_settle_timer #(
    parameter int SETTLE_TICKS = 200,
    parameter int POLL_LIMIT   = 5
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic stop,
    input  logic tick,
    input  logic ack,
    output logic busy,
    output logic lock,
    output logic fail
);
    import dclk_pkg::*;
    localparam int CW = $clog2(SETTLE_TICKS + 1);
    localparam int PW = $clog2(POLL_LIMIT + 1);

    tmr_state_t    st;
    logic [CW-1:0] cnt;
    logic [PW-1:0] pcnt;

    // state sequencing: settle window, bounded poll, terminal states
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= T_IDLE;
            cnt  <= '0;
            pcnt <= '0;
        end else if (stop) begin
            st <= T_IDLE;
        end else if (start) begin
            st  <= T_SETTLE;
            cnt <= '0;
        end else if (tick) begin
            case (st)
                T_SETTLE: begin
                    if (cnt == CW'(SETTLE_TICKS - 1)) begin
                        st   <= T_POLL;
                        pcnt <= '0;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                T_POLL: begin
                    if (ack)                               st <= T_LOCK;
                    else if (pcnt == PW'(POLL_LIMIT - 1))  st <= T_FAIL;
                    else                                   pcnt <= pcnt + 1'b1;
                end
                default: ;
            endcase
        end
    end

    // state flags
    always_comb begin
        busy = (st == T_SETTLE) || (st == T_POLL);
        lock = (st == T_LOCK);
        fail = (st == T_FAIL);
    end
endmodule

// File: rtl/dclk_synth_ctl.sv
// Top of the display clock synthesizer control front end: host write
// decode, enable gating during settle, read-back mux. Assumes host_wr is
// a single-cycle strobe and us_tick a single-cycle pulse.
module dclk_synth_ctl
    import dclk_pkg::*;
#(
    parameter int SETTLE_TICKS = 200,
    parameter int POLL_LIMIT   = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              us_tick,
    input  logic              host_wr,
    input  logic [2:0]        host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              osc_ack,
    output logic [WORD_W-1:0] div_word,
    output logic [WORD_W-1:0] ctrl_word,
    output logic [WORD_W-1:0] mult_word,
    output logic              locked,
    output logic              busy_err
);
    logic              set_wr, cmd_wr, en_req, dis_req, start, settling;
    logic [WORD_W-1:0] div_b;
    logic [P1_W-1:0]   p1_staged;
    logic [MUL_W-1:0]  mul_staged;

    // command decode; disable wins, enable ignored while settling
    always_comb begin
        set_wr  = host_wr && (host_addr == A_SETTINGS);
        cmd_wr  = host_wr && (host_addr == A_COMMAND);
        dis_req = cmd_wr && host_wdata[1];
        en_req  = cmd_wr && host_wdata[0] && !host_wdata[1];
        start   = en_req && !settling;
    end

    dclk_shadow_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .set_wr     (set_wr),
        .set_data   (settings_t'(host_wdata)),
        .start      (start),
        .stop       (dis_req),
        .div_a      (div_word),
        .div_b      (div_b),
        .p1_staged  (p1_staged),
        .mul_staged (mul_staged),
        .ctrl_q     (ctrl_word),
        .mult_q     (mult_word)
    );

    dclk_settle_timer #(
        .SETTLE_TICKS (SETTLE_TICKS),
        .POLL_LIMIT   (POLL_LIMIT)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (start),
        .stop  (dis_req),
        .tick  (us_tick),
        .ack   (osc_ack),
        .busy  (settling),
        .lock  (locked),
        .fail  (busy_err)
    );

    // host read-back mux; run bit hidden until lock
    always_comb begin
        case (host_addr)
            A_SETTINGS: host_rdata = div_word;
            A_DIV_B:    host_rdata = div_b;
            A_CTRL:     host_rdata = {ctrl_word[31] & locked, ctrl_word[30:0]};
            A_MULT:     host_rdata = mult_word;
            A_STAGED:   host_rdata = {mul_staged, p1_staged, 24'd0};
            A_STATUS:   host_rdata = {29'd0, settling, busy_err, locked};
            default:    host_rdata = '0;
        endcase
    end
endmodule

// File: rtl/dclk_synth_ctl_chk.sv
// Property checker for dclk_synth_ctl, attached with bind below.
module dclk_synth_ctl_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_wr,
    input logic [2:0]  host_addr,
    input logic [31:0] host_wdata,
    input logic [31:0] host_rdata,
    input logic [31:0] ctrl_word,
    input logic [31:0] mult_word,
    input logic        locked,
    input logic        busy_err,
    input logic        settling
);
    // R3
    settings_keep_ctrl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd0) |=> ($stable(ctrl_word) && $stable(mult_word)));
    // R6
    lock_needs_run_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> ctrl_word[31]);
    // R7
    lock_err_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(locked && busy_err));
    // R8
    disable_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd1 && host_wdata[1]) |=>
        (ctrl_word == 32'd0 && !locked && !busy_err));
    // R9
    run_bit_hidden_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_addr == 3'd2 && !locked) |-> !host_rdata[31]);
    // R10
    enable_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr == 3'd1 && host_wdata[0] && !host_wdata[1] && settling)
        |=> ($stable(ctrl_word) && $stable(mult_word)));
endmodule

bind dclk_synth_ctl dclk_synth_ctl_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_wr    (host_wr),
    .host_addr  (host_addr),
    .host_wdata (host_wdata),
    .host_rdata (host_rdata),
    .ctrl_word  (ctrl_word),
    .mult_word  (mult_word),
    .locked     (locked),
    .busy_err   (busy_err),
    .settling   (settling)
);

// File: tb/sim_dclk_synth_ctl.sv
`timescale 1ns/1ps
module sim_dclk_synth_ctl;
    localparam int SETTLE = 200;
    localparam int POLLS  = 5;

    logic        clk = 0, rst_n = 0, us_tick = 0, host_wr = 0, osc_ack = 0;
    logic [2:0]  host_addr = 0;
    logic [31:0] host_wdata = 0;
    logic [31:0] host_rdata, div_word, ctrl_word, mult_word;
    logic        locked, busy_err;

    int total = 0, bad = 0, cyc = 0, tick_div = 1;
    bit done = 0, model_on = 1;

    dclk_synth_ctl #(.SETTLE_TICKS(SETTLE), .POLL_LIMIT(POLLS)) u0 (
        .clk(clk), .rst_n(rst_n), .us_tick(us_tick), .host_wr(host_wr),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .osc_ack(osc_ack), .div_word(div_word), .ctrl_word(ctrl_word),
        .mult_word(mult_word), .locked(locked), .busy_err(busy_err));

    always #2.5 clk = ~clk;

    task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", what, act, exp);
        end
    endtask

    // reference model state (0 idle, 1 settle, 2 poll, 3 lock, 4 fail)
    logic [31:0] m_div, m_ctrl, m_mult;
    int m_p1, m_mul, m_st, m_ticks, m_polls;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_div = 0; m_ctrl = 0; m_mult = 0; m_p1 = 0; m_mul = 0;
            m_st = 0; m_ticks = 0; m_polls = 0;
        end else begin
            if (host_wr && host_addr == 0) begin
                m_div = (((host_wdata[23:16] - 2) & 255) << 16) |
                        (((host_wdata[15:8] - 2) & 255) << 8) |
                        ((host_wdata[7:0] - 2) & 255);
                m_p1 = host_wdata[27:24];
                m_mul = host_wdata[31:28];
            end
            if (host_wr && host_addr == 1 && host_wdata[1]) begin
                m_ctrl = 0; m_st = 0;
            end else if (host_wr && host_addr == 1 && host_wdata[0] && m_st != 1 && m_st != 2) begin
                m_ctrl = 32'h9400_0C00 | (m_p1 << 16);
                m_mult = (((m_mul - 1) & 255) << 8) | ((m_mul - 1) & 255);
                m_st = 1; m_ticks = 0;
            end else if (us_tick) begin
                if (m_st == 1) begin
                    m_ticks++;
                    if (m_ticks == SETTLE) begin m_st = 2; m_polls = 0; end
                end else if (m_st == 2) begin
                    m_polls++;
                    if (osc_ack) m_st = 3;
                    else if (m_polls == POLLS) m_st = 4;
                end
            end
        end
    end

    function automatic logic [31:0] m_read(input logic [2:0] a);
        case (a)
            0, 1: return m_div;
            2: return (m_st == 3) ? m_ctrl : (m_ctrl & 32'h7FFF_FFFF);
            3: return m_mult;
            4: return (m_mul << 28) | (m_p1 << 24);
            5: return {29'd0, (m_st == 1 || m_st == 2), m_st == 4, m_st == 3};
            default: return 0;
        endcase
    endfunction

    // per-clock comparison against the model, just after the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && model_on) begin
            chk(div_word, m_div, "R1 divisor word");
            chk(ctrl_word, m_ctrl, "R4 control word");
            chk(mult_word, m_mult, "R5 multiplier word");
            chk({31'd0, locked}, {31'd0, m_st == 3}, "R6 locked");
            chk({31'd0, busy_err}, {31'd0, m_st == 4}, "R7 busy_err");
            chk(host_rdata, m_read(host_addr), "R9 readback");
        end
    end

    // tick generator
    always @(negedge clk) begin
        cyc++;
        us_tick <= (tick_div == 1) ? 1'b1 : ((cyc % tick_div) == 0);
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        host_wr = 1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        host_addr = a;
        #1 d = host_rdata;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    logic [31:0] r0, r1;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R11 reset state
        chk(div_word | ctrl_word | mult_word, 0, "R11 words after reset");
        chk({30'd0, locked, busy_err}, 0, "R11 flags after reset");
        rd(3'd5, r0); chk(r0, 0, "R11 status after reset");

        // settings A: m2=7 m1=14 n=5 p1=3 mul=3
        wr(3'd0, 32'h3305_0E07);
        chk(div_word, 32'h0003_0C05, "R1 packed divisor A");
        rd(3'd0, r0); rd(3'd1, r1);
        chk(r1, r0, "R2 slot 1 equals slot 0");
        chk(ctrl_word | mult_word, 0, "R3 nothing committed before enable");
        rd(3'd4, r0); chk(r0, 32'h3300_0000, "R3 staged readback");

        osc_ack = 1;
        wr(3'd1, 32'h1);
        chk(ctrl_word, 32'h9403_0C00, "R4 control word A");
        chk(mult_word, 32'h0000_0202, "R5 multiplier word A");
        rd(3'd2, r0); chk(r0, 32'h1403_0C00, "R9 run bit hidden while settling");

        idle(100);
        // settings B mid-settle: m2=6 m1=12 n=4 p1=2 mul=5, then enable
        wr(3'd0, 32'h5204_0C06);
        chk(div_word, 32'h0002_0A04, "R1 packed divisor B");
        wr(3'd1, 32'h1);
        chk(ctrl_word, 32'h9403_0C00, "R10 enable during settle ignored");
        chk(mult_word, 32'h0000_0202, "R10 multiplier kept");
        idle(40);
        chk({31'd0, locked}, 0, "R6 no lock inside settle window");
        idle(70);
        chk({31'd0, locked}, 1, "R6 locked after settle");
        rd(3'd2, r0); chk(r0, 32'h9403_0C00, "R9 run bit visible after lock");

        wr(3'd1, 32'h2);
        chk(ctrl_word, 0, "R8 disable clears control");
        chk({31'd0, locked}, 0, "R8 disable clears lock");

        // no acknowledge: expect busy error
        osc_ack = 0;
        wr(3'd1, 32'h1);
        chk(ctrl_word, 32'h9402_0C00, "R4 control word B");
        chk(mult_word, 32'h0000_0404, "R5 multiplier word B");
        idle(SETTLE + POLLS + 10);
        chk({31'd0, busy_err}, 1, "R7 busy error raised");
        osc_ack = 1;
        idle(10);
        chk({31'd0, locked}, 0, "R7 ack ignored after failure");

        // sparse ticks, then lock
        tick_div = 3;
        wr(3'd1, 32'h1);
        chk({31'd0, busy_err}, 0, "R7 re-enable clears error");
        idle(3 * SETTLE - 20);
        chk({31'd0, locked}, 0, "R6 counts ticks not clocks");
        idle(40);
        chk({31'd0, locked}, 1, "R6 lock with sparse ticks");

        // enable and disable together: disable wins
        wr(3'd1, 32'h3);
        chk(ctrl_word, 0, "R8 disable wins over enable");
        rd(3'd5, r0); chk(r0, 0, "R8 status idle");
        idle(5);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog act=%0d exp=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule